// File: doc/BRIEF.md
# Hamming (7,4) Single-Error-Correcting Codec

This block protects 4-bit words with three even-parity check bits. The encoder path turns a data nibble into a 7-bit codeword. The decoder path takes a received codeword and recomputes the three parity groups. Comparing them with the received check bits gives a 3-bit syndrome. A nonzero syndrome names exactly one bit position, and that bit is inverted. The decoder then returns the repaired nibble, a flag that a repair took place, and the syndrome itself, which can be used for fault logging.

The encoder and decoder are independent paths that share one clock and reset, so the two can be used on different sides of a storage element or a link. Each path has a valid strobe and a single output register stage. Both paths have a fixed latency of one clock.

Top module: `ham74_codec`

## Requirements
- R1: The encoder codeword carries the data bits n3, n2, n1, n0 in bits 6, 5, 4, 3. It carries check bits i3, i2, i1 in bits 2, 1, 0.
- R2: Check bits use even parity: i3 = n3^n2^n1, i2 = n3^n2^n0 and i1 = n3^n1^n0.
- R3: The decoder syndrome is {s3,s2,s1}, where each sN is the received check bit XOR its value recomputed from the received data. A zero syndrome means the data passes through unchanged.
- R4: A syndrome of 111, 110, 101 or 011 marks an error in n3, n2, n1 or n0 respectively, and that data bit is inverted at the output.
- R5: A syndrome with exactly one bit set (100, 010 or 001, meaning i3, i2 or i1 is wrong) leaves the output data equal to the received data bits.
- R6: The corrected flag is high exactly when the syndrome is nonzero.
- R7: Each path has one register stage. Valid-out equals valid-in delayed by one clock, and the results appear in the same cycle as valid-out.
- R8: When valid-in is low at a clock edge, that path's data, syndrome and flag outputs keep their previous values.
- R9: A synchronous active-high reset clears both valid outputs, the codeword, the data, the syndrome and the flag to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_valid_i | input | 1 | Encoder input strobe |
| enc_data_i | input | 4 | Data nibble to encode (n3 in bit 3) |
| enc_valid_o | output | 1 | Encoder output strobe |
| enc_code_o | output | 7 | Registered codeword |
| dec_valid_i | input | 1 | Decoder input strobe |
| dec_code_i | input | 7 | Received codeword |
| dec_valid_o | output | 1 | Decoder output strobe |
| dec_data_o | output | 4 | Registered corrected nibble |
| dec_fixed_o | output | 1 | A single-bit repair was applied |
| dec_syndrome_o | output | 3 | Registered syndrome {s3,s2,s1} |

## Verification
All sixteen nibbles are sent through the encoder and compared with a precomputed codeword table. This shows that each parity group covers the right three data bits. Each codeword is also given to the decoder clean and with each of its seven bits inverted in turn. Data-bit flips test that the syndrome points at the right bit and that the repair inverts it. Check-bit flips test that a one-hot syndrome raises the flag but leaves the data alone. Directed steps cover the reset state, holding outputs while valid is low, and a reset applied in the middle of a stream.

// File: rtl/ham74_pkg.sv
package ham74_pkg;

  localparam int DATA_W = 4;
  localparam int CHK_W  = 3;
  localparam int CODE_W = DATA_W + CHK_W;

  // Row k selects the data bits covered by check bit k (k=0 -> i1, 1 -> i2, 2 -> i3).
  localparam logic [CHK_W-1:0][DATA_W-1:0] GROUP_MASK = {
    4'b1110,  // i3: n3 n2 n1
    4'b1101,  // i2: n3 n2 n0
    4'b1011   // i1: n3 n1 n0
  };

  // Syndrome pattern produced by an upset on data bit j.
  function automatic logic [CHK_W-1:0] data_column(input int j);
    logic [CHK_W-1:0] col;
    for (int k = 0; k < CHK_W; k++) col[k] = GROUP_MASK[k][j];
    return col;
  endfunction

endpackage

// File: rtl/ham74_parity.sv
module ham74_parity
  import ham74_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  output logic [CHK_W-1:0]  chk_o
);

  for (genvar k = 0; k < CHK_W; k++) begin : g_grp
    assign chk_o[k] = ^(data_i & GROUP_MASK[k]);
  end

endmodule

// File: rtl/ham74_enc.sv
module ham74_enc
  import ham74_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              valid_o,
  output logic [CODE_W-1:0] code_o
);

  logic [CHK_W-1:0]  chk;
  logic              valid_q;
  logic [CODE_W-1:0] code_q;

  ham74_parity u_par (
    .data_i (data_i),
    .chk_o  (chk)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      code_q  <= '0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) code_q <= {data_i, chk};
    end
  end

  assign valid_o = valid_q;
  assign code_o  = code_q;

endmodule

// File: rtl/ham74_dec.sv
module ham74_dec
  import ham74_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              valid_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              fixed_o,
  output logic [CHK_W-1:0]  syn_o
);

  logic [DATA_W-1:0] rx_data;
  logic [CHK_W-1:0]  rx_chk;
  logic [CHK_W-1:0]  re_chk;
  logic [CHK_W-1:0]  syn;
  logic [DATA_W-1:0] flip;

  assign rx_data = code_i[CODE_W-1:CHK_W];
  assign rx_chk  = code_i[CHK_W-1:0];

  ham74_parity u_par (
    .data_i (rx_data),
    .chk_o  (re_chk)
  );

  assign syn = rx_chk ^ re_chk;

  for (genvar j = 0; j < DATA_W; j++) begin : g_fix
    localparam logic [CHK_W-1:0] COL = data_column(j);
    assign flip[j] = (syn == COL);
  end

  logic              valid_q;
  logic [DATA_W-1:0] data_q;
  logic              fixed_q;
  logic [CHK_W-1:0]  syn_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      fixed_q <= 1'b0;
      syn_q   <= '0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) begin
        data_q  <= rx_data ^ flip;
        fixed_q <= |syn;
        syn_q   <= syn;
      end
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;
  assign fixed_o = fixed_q;
  assign syn_o   = syn_q;

endmodule

// File: rtl/ham74_codec.sv
module ham74_codec
  import ham74_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              enc_valid_i,
  input  logic [DATA_W-1:0] enc_data_i,
  output logic              enc_valid_o,
  output logic [CODE_W-1:0] enc_code_o,
  input  logic              dec_valid_i,
  input  logic [CODE_W-1:0] dec_code_i,
  output logic              dec_valid_o,
  output logic [DATA_W-1:0] dec_data_o,
  output logic              dec_fixed_o,
  output logic [CHK_W-1:0]  dec_syndrome_o
);

  ham74_enc u_enc (
    .clk     (clk),
    .rst     (rst),
    .valid_i (enc_valid_i),
    .data_i  (enc_data_i),
    .valid_o (enc_valid_o),
    .code_o  (enc_code_o)
  );

  ham74_dec u_dec (
    .clk     (clk),
    .rst     (rst),
    .valid_i (dec_valid_i),
    .code_i  (dec_code_i),
    .valid_o (dec_valid_o),
    .data_o  (dec_data_o),
    .fixed_o (dec_fixed_o),
    .syn_o   (dec_syndrome_o)
  );

endmodule

// File: rtl/ham74_codec_checker.sv
module ham74_codec_checker (
  input logic       clk,
  input logic       rst,
  input logic       enc_valid_i,
  input logic [3:0] enc_data_i,
  input logic       enc_valid_o,
  input logic [6:0] enc_code_o,
  input logic       dec_valid_i,
  input logic [6:0] dec_code_i,
  input logic       dec_valid_o,
  input logic [3:0] dec_data_o,
  input logic       dec_fixed_o,
  input logic [2:0] dec_syndrome_o
);

  assert_enc_data_R1: assert property (@(posedge clk) disable iff (rst)
    enc_valid_i |=> enc_code_o[6:3] == $past(enc_data_i));

  assert_enc_parity_R2: assert property (@(posedge clk) disable iff (rst)
    enc_valid_o |-> (^(enc_code_o & 7'b1110100)) == 1'b0 &&
                    (^(enc_code_o & 7'b1101010)) == 1'b0 &&
                    (^(enc_code_o & 7'b1011001)) == 1'b0);

  // R3, R5: no repair on data when the syndrome has at most one bit set
  assert_data_pass_R5: assert property (@(posedge clk) disable iff (rst)
    dec_valid_i |=> ($countones(dec_syndrome_o) > 1) ||
                    dec_data_o == $past(dec_code_i[6:3]));

  assert_flag_R6: assert property (@(posedge clk) disable iff (rst)
    dec_valid_o |-> dec_fixed_o == (dec_syndrome_o != 3'b000));

  assert_lat_on_R7: assert property (@(posedge clk) disable iff (rst)
    enc_valid_i && dec_valid_i |=> enc_valid_o && dec_valid_o);

  assert_lat_off_R7: assert property (@(posedge clk) disable iff (rst)
    !enc_valid_i && !dec_valid_i |=> !enc_valid_o && !dec_valid_o);

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !dec_valid_i |=> $stable(dec_data_o) && $stable(dec_syndrome_o) && $stable(dec_fixed_o));

  assert_reset_R9: assert property (@(posedge clk)
    rst |=> !enc_valid_o && !dec_valid_o && enc_code_o == 7'd0 &&
            dec_data_o == 4'd0 && !dec_fixed_o && dec_syndrome_o == 3'd0);

endmodule

bind ham74_codec ham74_codec_checker u_chk (
  .clk            (clk),
  .rst            (rst),
  .enc_valid_i    (enc_valid_i),
  .enc_data_i     (enc_data_i),
  .enc_valid_o    (enc_valid_o),
  .enc_code_o     (enc_code_o),
  .dec_valid_i    (dec_valid_i),
  .dec_code_i     (dec_code_i),
  .dec_valid_o    (dec_valid_o),
  .dec_data_o     (dec_data_o),
  .dec_fixed_o    (dec_fixed_o),
  .dec_syndrome_o (dec_syndrome_o)
);

// File: tb/ham74_codec_bench.sv
module ham74_codec_bench;

  logic       clk = 1'b0;
  logic       rst;
  logic       enc_valid_i;
  logic [3:0] enc_data_i;
  logic       enc_valid_o;
  logic [6:0] enc_code_o;
  logic       dec_valid_i;
  logic [6:0] dec_code_i;
  logic       dec_valid_o;
  logic [3:0] dec_data_o;
  logic       dec_fixed_o;
  logic [2:0] dec_syndrome_o;

  int n_checks = 0;
  int n_errors = 0;

  always #4 clk = ~clk;

  ham74_codec u_ham74_codec (
    .clk            (clk),
    .rst            (rst),
    .enc_valid_i    (enc_valid_i),
    .enc_data_i     (enc_data_i),
    .enc_valid_o    (enc_valid_o),
    .enc_code_o     (enc_code_o),
    .dec_valid_i    (dec_valid_i),
    .dec_code_i     (dec_code_i),
    .dec_valid_o    (dec_valid_o),
    .dec_data_o     (dec_data_o),
    .dec_fixed_o    (dec_fixed_o),
    .dec_syndrome_o (dec_syndrome_o)
  );

  // Expected codeword for each nibble: {n3 n2 n1 n0, i3 i2 i1}
  localparam logic [6:0] CODE_TBL [16] = '{
    7'b0000_000, 7'b0001_011, 7'b0010_101, 7'b0011_110,
    7'b0100_110, 7'b0101_101, 7'b0110_011, 7'b0111_000,
    7'b1000_111, 7'b1001_100, 7'b1010_010, 7'b1011_001,
    7'b1100_001, 7'b1101_010, 7'b1110_100, 7'b1111_111
  };

  // Expected syndrome when codeword bit p is inverted
  localparam logic [2:0] SYN_TBL [7] = '{
    3'b001, 3'b010, 3'b100, 3'b011, 3'b101, 3'b110, 3'b111
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic check_idle_zero(input string req);
    check(enc_valid_o == 1'b0, req, "enc_valid_o", 32'(enc_valid_o), 0);
    check(dec_valid_o == 1'b0, req, "dec_valid_o", 32'(dec_valid_o), 0);
    check(enc_code_o == 7'd0, req, "enc_code_o", 32'(enc_code_o), 0);
    check(dec_data_o == 4'd0, req, "dec_data_o", 32'(dec_data_o), 0);
    check(dec_fixed_o == 1'b0, req, "dec_fixed_o", 32'(dec_fixed_o), 0);
    check(dec_syndrome_o == 3'd0, req, "dec_syndrome_o", 32'(dec_syndrome_o), 0);
  endtask

  initial begin
    #(8 * 200000);
    n_errors++;
    n_checks++;
    $display("FAIL R7 watchdog: got running expected finished");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    rst         = 1'b1;
    enc_valid_i = 1'b0;
    enc_data_i  = 4'd0;
    dec_valid_i = 1'b0;
    dec_code_i  = 7'd0;
    repeat (3) @(posedge clk);
    #1;
    check_idle_zero("R9");
    @(negedge clk);
    rst = 1'b0;

    // Table walk: every nibble, clean and with each single-bit upset
    for (int d = 0; d < 16; d++) begin
      for (int f = 0; f < 8; f++) begin
        @(negedge clk);
        enc_valid_i = 1'b1;
        enc_data_i  = 4'(d);
        dec_valid_i = 1'b1;
        dec_code_i  = CODE_TBL[d] ^ ((f < 7) ? 7'(1 << f) : 7'd0);
        @(posedge clk);
        #1;
        if (f == 7)
          check(enc_code_o == CODE_TBL[d], "R1 R2", "enc_code_o",
                32'(enc_code_o), 32'(CODE_TBL[d]));
        check(dec_data_o == 4'(d), (f == 7) ? "R3" : ((f >= 3) ? "R4" : "R5"),
              "dec_data_o", 32'(dec_data_o), 32'(d));
        check(dec_syndrome_o == ((f == 7) ? 3'd0 : SYN_TBL[f]), "R3",
              "dec_syndrome_o", 32'(dec_syndrome_o),
              32'((f == 7) ? 3'd0 : SYN_TBL[f]));
        check(dec_fixed_o == (f != 7), "R6", "dec_fixed_o",
              32'(dec_fixed_o), 32'(f != 7));
        check(enc_valid_o && dec_valid_o, "R7", "valid outputs",
              32'({enc_valid_o, dec_valid_o}), 32'h3);
      end
    end

    // Hold: valid low, inputs change, outputs keep the last result
    @(negedge clk);
    enc_valid_i = 1'b0;
    enc_data_i  = 4'h6;
    dec_valid_i = 1'b0;
    dec_code_i  = 7'b0110_000;
    @(posedge clk);
    #1;
    check(enc_valid_o == 1'b0 && dec_valid_o == 1'b0, "R7", "valid drop",
          32'({enc_valid_o, dec_valid_o}), 0);
    check(enc_code_o == CODE_TBL[15], "R8", "enc_code_o hold",
          32'(enc_code_o), 32'(CODE_TBL[15]));
    check(dec_data_o == 4'hf, "R8", "dec_data_o hold", 32'(dec_data_o), 32'hf);
    check(dec_syndrome_o == 3'd0 && dec_fixed_o == 1'b0, "R8", "syndrome/flag hold",
          32'({dec_fixed_o, dec_syndrome_o}), 0);

    // Load a repaired word, then reset in mid-stream
    @(negedge clk);
    enc_valid_i = 1'b1;
    enc_data_i  = 4'h5;
    dec_valid_i = 1'b1;
    dec_code_i  = CODE_TBL[5] ^ 7'b0010000;
    @(posedge clk);
    #1;
    check(dec_data_o == 4'h5 && dec_fixed_o, "R4", "n1 repair",
          32'({dec_fixed_o, dec_data_o}), 32'h15);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    check_idle_zero("R9");
    @(negedge clk);
    rst         = 1'b0;
    enc_valid_i = 1'b0;
    dec_valid_i = 1'b0;
    @(posedge clk);
    #1;
    check(enc_valid_o == 1'b0 && dec_valid_o == 1'b0, "R7", "idle after reset",
          32'({enc_valid_o, dec_valid_o}), 0);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule